// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block chooses the 9-bit address of the microinstruction that follows the current one in a 512-word control store. Each microinstruction supplies an 8-bit successor field, an active-low fetch marker, a conditional-branch flag and a 3-bit condition selector. The block registers these on every clock edge and combines them with live inputs (the instruction register, the status flags, trap lines and interrupt lines) to form the address that the control store reads during the next cycle.

The address comes from one of three sources. The successor field, placed in the upper half of the store, is the usual source. The opcode held in the instruction register, used directly as a lower-half address, is selected by the fetch microinstruction. The third source is a 16-line priority encoder whose index lands at the bottom of the upper half. A successor field of zero ends an instruction and consults the encoder. A trap, a reset, or a conditional branch whose condition is false cancels the registered successor at once. The address then goes through the encoder, so mid-sequence exceptions and aborted branches are handled the same way as a normal instruction boundary.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_n` is low, and until the first clock edge after the internal reset release has loaded the microinstruction fields, `uaddr` is 0x100 (encoder line 0). Asserting `rst_n` forces 0x100 at once, without waiting for a clock edge.
- R2: When nothing cancels the registered successor field and that field is neither 0x00 nor the IR case of R3, `uaddr` is 0x100 OR the field.
- R3: A registered field of 0xFF together with an active (low) fetch marker gives `uaddr` = {0, `ir_opcode`}. A field of 0xFF with the marker inactive follows R2 (0x1FF).
- R4: A registered field of 0x00 gives `uaddr` = 0x100 OR the encoder index, whatever the fetch marker is.
- R5: Encoder lines are ranked with index 0 the highest priority: line 0 is the pending reset, line 1+i is `trap_req[i]`, line 8+j is `irq_req[j]`, and line 15 is fetch, which is always active. The output is the lowest active index, so with nothing pending the address is 0x10F.
- R6: Any set bit of `trap_req` makes `uaddr` come from the encoder in the same cycle, whatever the registered field, marker or branch flag.
- R7: Interrupt lines have no effect on `uaddr` unless the encoder path is selected. They are ignored in the middle of a sequence.
- R8: If the registered branch flag is set and the selected condition is false, the address comes from the encoder. If the condition is true, the address follows R2/R3/R4.
- R9: Condition selector codes use `status_flags` bit0 = Z, bit1 = N, bit2 = C, bit3 = V: 0 = Z, 1 = !Z, 2 = N, 3 = C, 4 = !C, 5 = V, 6 = N xor V, 7 = always true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| uc_next | input | 8 | Successor field of the microinstruction being issued |
| uc_init_n | input | 1 | Active-low fetch marker of that microinstruction |
| uc_br_en | input | 1 | Conditional-branch flag of that microinstruction |
| uc_cond_sel | input | 3 | Condition selector of that microinstruction |
| status_flags | input | 4 | Live condition bits {V,C,N,Z} |
| ir_opcode | input | 8 | Instruction register |
| trap_req | input | 7 | Trap request lines, bit 0 highest priority |
| irq_req | input | 7 | Interrupt request lines, bit 0 highest priority |
| uaddr | output | 9 | Address of the next microinstruction |

## Verification
The hardest situation to reach is a cancellation that competes with another source in the same cycle. Examples are a trap that arrives while a fetch microinstruction is registered with 0xFF, or a failed branch while interrupts are pending, where the encoder has to win and pick interrupt line 8 and not fetch. Random stimulus skews the successor field toward 0x00 and 0xFF, sets the fetch marker and branch flag often, and toggles trap and interrupt lines independently, so these collisions occur many times. Directed cases add an asynchronous reset in mid-run and exact priority patterns.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    COND_ZERO    = 3'd0,
    COND_NZERO   = 3'd1,
    COND_NEG     = 3'd2,
    COND_CARRY   = 3'd3,
    COND_NCARRY  = 3'd4,
    COND_OVF     = 3'd5,
    COND_SLT     = 3'd6,
    COND_ALWAYS  = 3'd7
  } cond_sel_e;

  localparam int FLAG_Z = 0;
  localparam int FLAG_N = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_W = 4;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/useq_prio_enc.sv
module useq_prio_enc #(
  parameter int NLINES = 16,
  localparam int IW = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] lines,
  output logic [IW-1:0]     idx
);
  always_comb begin
    idx = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (lines[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
  import useq_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [2:0]        sel,
  output logic              met
);
  cond_sel_e sel_e;

  always_comb begin
    sel_e = cond_sel_e'(sel);
    unique case (sel_e)
      COND_ZERO:   met = flags[FLAG_Z];
      COND_NZERO:  met = ~flags[FLAG_Z];
      COND_NEG:    met = flags[FLAG_N];
      COND_CARRY:  met = flags[FLAG_C];
      COND_NCARRY: met = ~flags[FLAG_C];
      COND_OVF:    met = flags[FLAG_V];
      COND_SLT:    met = flags[FLAG_N] ^ flags[FLAG_V];
      default:     met = 1'b1;
    endcase
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int FW    = 8,
  parameter int NTRAP = 7,
  parameter int NIRQ  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FW-1:0]     uc_next,
  input  logic              uc_init_n,
  input  logic              uc_br_en,
  input  logic [2:0]        uc_cond_sel,
  input  logic [FLAG_W-1:0] status_flags,
  input  logic [FW-1:0]     ir_opcode,
  input  logic [NTRAP-1:0]  trap_req,
  input  logic [NIRQ-1:0]   irq_req,
  output logic [FW:0]       uaddr
);
  localparam int NLINES = NTRAP + NIRQ + 2;
  localparam int IW     = $clog2(NLINES);
  localparam int PADW   = FW - IW;

  logic          rst_sync_n;
  logic [FW-1:0] next_q,   next_d;
  logic          init_n_q, init_n_d;
  logic          br_en_q,  br_en_d;
  logic [2:0]    csel_q,   csel_d;
  logic          rst_pend_q, rst_pend_d;
  logic          step;

  logic              cond_met;
  logic [NLINES-1:0] enc_lines;
  logic [IW-1:0]     enc_idx;
  logic              force_vec;

  useq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Fields of the issued microinstruction are taken every cycle.
  assign step = 1'b1;

  always_comb begin
    next_d     = next_q;
    init_n_d   = init_n_q;
    br_en_d    = br_en_q;
    csel_d     = csel_q;
    rst_pend_d = 1'b0;
    if (step) begin
      next_d   = uc_next;
      init_n_d = uc_init_n;
      br_en_d  = uc_br_en;
      csel_d   = uc_cond_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      next_q     <= '0;
      init_n_q   <= 1'b1;
      br_en_q    <= 1'b0;
      csel_q     <= '0;
      rst_pend_q <= 1'b1;
    end else begin
      next_q     <= next_d;
      init_n_q   <= init_n_d;
      br_en_q    <= br_en_d;
      csel_q     <= csel_d;
      rst_pend_q <= rst_pend_d;
    end
  end

  useq_cond_eval u_cond (
    .flags (status_flags),
    .sel   (csel_q),
    .met   (cond_met)
  );

  // line 0 reset, traps next, interrupts after, fetch last and always on
  assign enc_lines = {1'b1, irq_req, trap_req, rst_pend_q};

  useq_prio_enc #(.NLINES(NLINES)) u_enc (
    .lines (enc_lines),
    .idx   (enc_idx)
  );

  // cancellation of the registered successor: reset, trap, failed branch
  assign force_vec = rst_pend_q | (|trap_req) | (br_en_q & ~cond_met);

  always_comb begin
    if (force_vec || next_q == '0)
      uaddr = {1'b1, {PADW{1'b0}}, enc_idx};
    else if (next_q == '1 && !init_n_q)
      uaddr = {1'b0, ir_opcode};
    else
      uaddr = {1'b1, next_q};
  end
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int FW    = 8,
  parameter int NTRAP = 7,
  parameter int NIRQ  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_pend,
  input logic [FW-1:0]    uc_next,
  input logic             uc_init_n,
  input logic             uc_br_en,
  input logic [FW-1:0]    ir_opcode,
  input logic [NTRAP-1:0] trap_req,
  input logic [NIRQ-1:0]  irq_req,
  input logic [FW:0]      uaddr
);
  localparam int NLINES = NTRAP + NIRQ + 2;

  assert_reset_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |-> uaddr == {1'b1, FW'(0)});

  assert_field_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pend && trap_req == '0 && !$past(uc_br_en) &&
     $past(uc_next) != '0 && $past(uc_next) != '1)
    |-> uaddr == {1'b1, $past(uc_next)});

  assert_opcode_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pend && trap_req == '0 && !$past(uc_br_en) &&
     $past(uc_next) == '1 && !$past(uc_init_n))
    |-> uaddr == {1'b0, ir_opcode});

  assert_idle_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pend && trap_req == '0 && irq_req == '0 && $past(uc_next) == '0)
    |-> uaddr == {1'b1, FW'(NLINES - 1)});

  assert_trap_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pend && trap_req != '0)
    |-> (uaddr[FW] && uaddr[FW-1:0] >= FW'(1) && uaddr[FW-1:0] <= FW'(NTRAP)));
endmodule

bind useq_next_addr useq_next_addr_chk #(
  .FW(FW), .NTRAP(NTRAP), .NIRQ(NIRQ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_pend  (rst_pend_q),
  .uc_next   (uc_next),
  .uc_init_n (uc_init_n),
  .uc_br_en  (uc_br_en),
  .ir_opcode (ir_opcode),
  .trap_req  (trap_req),
  .irq_req   (irq_req),
  .uaddr     (uaddr)
);

// File: tb/useq_next_addr_bench.sv
module useq_next_addr_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] uc_next;
  logic       uc_init_n;
  logic       uc_br_en;
  logic [2:0] uc_cond_sel;
  logic [3:0] status_flags;
  logic [7:0] ir_opcode;
  logic [6:0] trap_req;
  logic [6:0] irq_req;
  logic [8:0] uaddr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  useq_next_addr u_useq_next_addr (
    .clk(clk), .rst_n(rst_n), .uc_next(uc_next), .uc_init_n(uc_init_n),
    .uc_br_en(uc_br_en), .uc_cond_sel(uc_cond_sel), .status_flags(status_flags),
    .ir_opcode(ir_opcode), .trap_req(trap_req), .irq_req(irq_req), .uaddr(uaddr)
  );

  function automatic bit cond_of(input logic [2:0] s, input logic [3:0] f);
    case (s)
      3'd0: return f[0];
      3'd1: return !f[0];
      3'd2: return f[1];
      3'd3: return f[2];
      3'd4: return !f[2];
      3'd5: return f[3];
      3'd6: return f[1] ^ f[3];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [8:0] vec_of(input logic [6:0] t, input logic [6:0] q);
    for (int i = 0; i < 7; i++) if (t[i]) return 9'h101 + 9'(i);
    for (int j = 0; j < 7; j++) if (q[j]) return 9'h108 + 9'(j);
    return 9'h10F;
  endfunction

  function automatic logic [8:0] exp_addr(input logic [7:0] nx, input logic ini,
      input logic br, input logic [2:0] cs, input logic [3:0] fl,
      input logic [7:0] ir, input logic [6:0] t, input logic [6:0] q);
    if (t != 0 || (br && !cond_of(cs, fl)) || nx == 8'h00) return vec_of(t, q);
    if (nx == 8'hFF && !ini) return {1'b0, ir};
    return {1'b1, nx};
  endfunction

  function automatic string tag_of(input logic [7:0] nx, input logic ini,
      input logic br, input logic [2:0] cs, input logic [3:0] fl, input logic [6:0] t);
    if (t != 0) return "R6";
    if (br && !cond_of(cs, fl)) return "R8";
    if (nx == 8'h00) return "R4";
    if (nx == 8'hFF) return "R3";
    return "R2";
  endfunction

  task automatic check(input logic [8:0] exp, input string req);
    n_cmp++;
    if (uaddr !== exp) begin
      n_bad++;
      $display("FAIL %s: uaddr=%h expected=%h", req, uaddr, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] nx, input logic ini, input logic br,
      input logic [2:0] cs, input logic [3:0] fl, input logic [7:0] ir,
      input logic [6:0] t, input logic [6:0] q, input string req);
    uc_next = nx; uc_init_n = ini; uc_br_en = br; uc_cond_sel = cs;
    status_flags = fl; ir_opcode = ir; trap_req = t; irq_req = q;
    @(posedge clk); #2;
    check(exp_addr(nx, ini, br, cs, fl, ir, t, q),
          req == "" ? tag_of(nx, ini, br, cs, fl, t) : req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 check(9'h100, "R1");
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2 check(9'h100, "R1");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    uc_next = 8'h00; uc_init_n = 1'b1; uc_br_en = 1'b0; uc_cond_sel = 3'd0;
    status_flags = 4'h0; ir_opcode = 8'h00; trap_req = '0; irq_req = '0;
    #1 do_reset();

    // R2 / R4 / R5 basics
    cyc(8'h10, 1, 0, 0, 0, 8'h34, 0, 0, "R2");
    cyc(8'h00, 1, 0, 0, 0, 8'h34, 0, 0, "R5");           // idle -> fetch 0x10F
    cyc(8'hFF, 0, 0, 0, 0, 8'h34, 0, 0, "R3");           // fetch -> opcode
    cyc(8'hFF, 1, 0, 0, 0, 8'h34, 0, 0, "R3");           // no marker -> 0x1FF
    cyc(8'h00, 0, 0, 0, 0, 8'h34, 0, 7'h05, "R4");       // irq0 -> 0x108
    // R7: interrupts ignored mid-sequence
    cyc(8'h23, 1, 0, 0, 0, 8'h00, 0, 7'h7F, "R7");
    cyc(8'hFF, 0, 0, 0, 0, 8'h5A, 0, 7'h7F, "R7");
    // R5 / R6 priority
    cyc(8'h23, 1, 0, 0, 0, 8'h00, 7'b0100100, 7'h01, "R5"); // trap2 -> 0x103
    cyc(8'hFF, 0, 0, 0, 0, 8'h77, 7'h40, 7'h00, "R6");      // trap6 beats fetch
    cyc(8'h00, 1, 0, 0, 0, 8'h00, 0, 7'h40, "R5");          // irq6 -> 0x10E
    // R8 / R9 conditional branches
    cyc(8'h44, 1, 1, 3'd0, 4'b0000, 8'h00, 0, 7'h01, "R8"); // Z false -> 0x108
    cyc(8'h44, 1, 1, 3'd0, 4'b0001, 8'h00, 0, 7'h01, "R8"); // Z true -> 0x144
    cyc(8'h45, 1, 1, 3'd6, 4'b1000, 8'h00, 0, 0, "R9");     // N^V true
    cyc(8'h45, 1, 1, 3'd6, 4'b1010, 8'h00, 0, 0, "R9");     // N^V false
    cyc(8'h46, 1, 1, 3'd4, 4'b0100, 8'h00, 0, 0, "R9");     // !C false
    cyc(8'h47, 1, 1, 3'd7, 4'b0000, 8'h00, 0, 0, "R9");     // always

    // R10-style async reset in mid-run, part of R1
    cyc(8'h55, 1, 0, 0, 0, 8'h00, 0, 0, "R2");
    #1 rst_n = 1'b0;
    #1 check(9'h100, "R1");
    do_reset();

    for (int k = 0; k < 400; k++) begin
      logic [7:0] nx;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 7));
      nx = (pick == 0) ? 8'h00 : (pick == 1) ? 8'hFF : 8'($urandom);
      cyc(nx, ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0),
          3'($urandom), 4'($urandom), 8'($urandom),
          ($urandom_range(0, 7) == 0) ? 7'($urandom) : 7'h00,
          ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h00, "");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule